// File: doc/BRIEF.md
# Test-Mode Line Source Selector

This block picks the serial bit stream that feeds the trigger input of a downstream line coder. In normal service it forwards the traffic data. When a maintenance request is raised, a small control code switches the trigger to one of three other sources: a looped-back test data stream, a constant low level, or a test tone at half the reference clock rate. Everything runs on one reference clock, nominally 4915.2 kHz, so the tone comes out at 2457.6 kHz.

The three control pins may change at any time relative to the clock. They pass through a two-stage synchronizer before they are decoded. The chosen bit is then captured in a single output flip-flop, so the trigger line only changes on a clock edge and a change of mode cannot produce a runt pulse. The two data streams are expected to be synchronous to the reference clock already. The half-rate divider is cleared whenever tone mode is not selected. Each entry into tone mode therefore starts from the same phase.

Top module: `line_src_sel`

## Requirements
- R1: With the active-low test request `test_n_i` = 1, `trig_o` carries `traffic_i`, whatever the code bits are.
- R2: With `test_n_i` = 0, `code_a_i` = 1 and `code_b_i` = 1, `trig_o` carries `loop_i`.
- R3: With `test_n_i` = 0, `code_a_i` = 0 and `code_b_i` = 1, `trig_o` is held at 0 and ignores both data streams.
- R4: With `test_n_i` = 0, `code_a_i` = 0 and `code_b_i` = 0, `trig_o` toggles on every clock cycle, which gives a square wave at half the reference rate.
- R5: With `test_n_i` = 0, `code_a_i` = 1 and `code_b_i` = 0, `trig_o` is held at 0 and ignores both data streams.
- R6: The first output cycle after tone mode is entered is 0, and the 1 follows on the next cycle. Outside tone mode the divider stays at 0, so every entry into tone mode repeats this phase.
- R7: A change on the control pins that is captured at clock edge k first reaches `trig_o` at edge k+2. Until then `trig_o` follows the old source.
- R8: In a data mode, a data bit sampled at a clock edge appears on `trig_o` directly after that same edge. The latency is one register stage.
- R9: While `rst_ni` is 0, `trig_o` is 0. The synchronizer resets to the traffic selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (4915.2 kHz nominal) |
| rst_ni | input | 1 | Synchronous active-low reset |
| test_n_i | input | 1 | Test request, active low, asynchronous |
| code_a_i | input | 1 | First test-code bit, asynchronous |
| code_b_i | input | 1 | Second test-code bit, asynchronous |
| traffic_i | input | 1 | Normal traffic bit stream, synchronous to clk_i |
| loop_i | input | 1 | Looped-back test bit stream, synchronous to clk_i |
| trig_o | output | 1 | Registered trigger stream to the line coder |

## Verification
On every cycle, the assertions check these rules:
- A decoded data source is copied to the output one cycle later.
- Both idle codes give 0 on the next cycle.
- The divider is held clear outside tone mode and inverts on every cycle inside it.

The bench is the only place that shows what is seen at the pins:
- The full mapping from the three control pins to the output, across every code and in two orders.
- The three-edge latency of a control change, which is the synchronizer depth plus the output register.
- The fixed tone phase when tone mode is entered again after it ends on an odd cycle.
- The output level held during reset.

// File: rtl/tsel_pkg.sv
// Package: shared types for the test-mode line source selector.
// Assumes: consumers import or scope-qualify the enum below.
package tsel_pkg;

    // Width of the raw control word {test_n, code_a, code_b}.
    localparam int unsigned CTRL_W = 3;

    // Decoded trigger source.
    typedef enum logic [1:0] {
        SRC_TRAFFIC = 2'd0,
        SRC_LOOP    = 2'd1,
        SRC_TONE    = 2'd2,
        SRC_IDLE    = 2'd3
    } src_e;

endpackage

// File: rtl/tsel_sync.sv
// Module: tsel_sync
// Multi-stage synchronizer for a bundle of slowly changing control bits.
// Assumes: the bits are quasi-static, so a skew of one cycle between the bits
// of the bundle only produces a brief passing code, which the caller tolerates.
module tsel_sync #(
    parameter int unsigned         WIDTH     = 3,
    parameter int unsigned         STAGES    = 2,
    parameter logic [WIDTH-1:0]    RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous word through the stage chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RESET_VAL;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tsel_decode.sv
// Module: tsel_decode
// Maps the synchronized control word {test_n, code_a, code_b} to a source.
// Assumes: the input word is already synchronous; the output is combinational.
module tsel_decode
    import tsel_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl_i,
    output src_e              src_o
);

    // Decode the test request and code bits; unused codes fall back to idle.
    always_comb begin
        if (ctrl_i[2]) begin
            src_o = SRC_TRAFFIC;
        end else begin
            unique case (ctrl_i[1:0])
                2'b11:   src_o = SRC_LOOP;
                2'b00:   src_o = SRC_TONE;
                default: src_o = SRC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tsel_tone.sv
// Module: tsel_tone
// Half-rate tone generator: a toggle flop that runs only while enabled.
// Assumes: enable is synchronous; the flop is cleared while disabled.
module tsel_tone (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tone_o
);

    logic tone_q;

    // Toggle while enabled, hold at zero otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            tone_q <= 1'b0;
        end else begin
            tone_q <= ~tone_q;
        end
    end

    assign tone_o = tone_q;

endmodule

// File: rtl/tsel_outreg.sv
// Module: tsel_outreg
// Selects the trigger bit for the decoded source and registers it.
// Assumes: all inputs are synchronous to clk_i.
module tsel_outreg
    import tsel_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  src_e src_i,
    input  logic traffic_i,
    input  logic loop_i,
    input  logic tone_i,
    output logic trig_o
);

    logic pick;
    logic trig_q;

    // Choose the bit that belongs to the current source.
    always_comb begin
        unique case (src_i)
            SRC_TRAFFIC: pick = traffic_i;
            SRC_LOOP:    pick = loop_i;
            SRC_TONE:    pick = tone_i;
            default:     pick = 1'b0;
        endcase
    end

    // Register the chosen bit so that the output changes only on a clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= pick;
        end
    end

    assign trig_o = trig_q;

endmodule

// File: rtl/line_src_sel.sv
// Module: line_src_sel
// Top of the test-mode line source selector: synchronizer, decoder, half-rate
// tone generator and the registered output mux.
// Assumes: one reference clock; the control pins are asynchronous, and the
// data streams are synchronous to the reference clock.
module line_src_sel
    import tsel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic test_n_i,
    input  logic code_a_i,
    input  logic code_b_i,
    input  logic traffic_i,
    input  logic loop_i,
    output logic trig_o
);

    localparam logic [CTRL_W-1:0] CTRL_RST = {1'b1, {(CTRL_W-1){1'b0}}};

    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_sync;
    src_e              src_w;
    logic              tone_w;
    logic              tone_en;

    assign ctrl_raw = {test_n_i, code_a_i, code_b_i};
    assign tone_en  = (src_w == SRC_TONE);

    tsel_sync #(
        .WIDTH     (CTRL_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CTRL_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ctrl_raw),
        .sync_o  (ctrl_sync)
    );

    tsel_decode u_dec (
        .ctrl_i (ctrl_sync),
        .src_o  (src_w)
    );

    tsel_tone u_tone (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (tone_en),
        .tone_o (tone_w)
    );

    tsel_outreg u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_w),
        .traffic_i (traffic_i),
        .loop_i    (loop_i),
        .tone_i    (tone_w),
        .trig_o    (trig_o)
    );

endmodule

// File: rtl/line_src_sel_chk.sv
// Module: line_src_sel_chk
// Checker bound into line_src_sel; relates the decoded source, the divider
// and the output register across cycles.
// Assumes: it is attached through the bind statement at the end of this file.
module line_src_sel_chk
    import tsel_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       traffic_i,
    input logic       loop_i,
    input logic [1:0] src,
    input logic       tone,
    input logic       trig_o
);

    AST_TRAFFIC_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_TRAFFIC) |=> (trig_o == $past(traffic_i))); // R1

    AST_LOOP_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_LOOP) |=> (trig_o == $past(loop_i))); // R2

    AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_IDLE) |=> (trig_o == 1'b0)); // R3

    AST_TONE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_TONE) |=> (trig_o == $past(tone))); // R4

    AST_TONE_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src == SRC_TONE) |=> (tone != $past(tone))); // R4

    AST_TONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src != SRC_TONE) |=> (tone == 1'b0)); // R6

endmodule

bind line_src_sel line_src_sel_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .traffic_i (traffic_i),
    .loop_i    (loop_i),
    .src       (src_w),
    .tone      (tone_w),
    .trig_o    (trig_o)
);

// File: tb/line_src_sel_tb.sv
// Bench for line_src_sel: sweeps every control code in two orders with
// arithmetic data patterns, plus reset, latency and tone-phase checks.
module line_src_sel_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_n = 1'b1;
    logic code_a = 1'b0;
    logic code_b = 1'b0;
    logic traffic = 1'b0;
    logic loopd = 1'b0;
    logic trig;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    line_src_sel u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .test_n_i  (test_n),
        .code_a_i  (code_a),
        .code_b_i  (code_b),
        .traffic_i (traffic),
        .loop_i    (loopd),
        .trig_o    (trig)
    );

    // Compare one output sample against its expected value.
    task automatic check(input string req, input logic exp);
        n_tests++;
        if (trig !== exp) begin
            n_fail++;
            $display("FAIL %s: trig=%b expected=%b at %0t", req, trig, exp, $time);
        end
    endtask

    // Apply one control code, wait out the latency, then check ncyc cycles.
    task automatic run_code(input logic [2:0] code, input int ncyc, input int seed);
        @(negedge clk);
        {test_n, code_a, code_b} = code;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < ncyc; i++) begin
            logic tb;
            logic lb;
            logic exp;
            tb = (((i * 5 + seed) % 7) > 2);
            lb = (((i + seed) % 3) == 0);
            traffic = tb;
            loopd   = lb;
            if (code[2])               exp = tb;          // R1 traffic
            else if (code[1:0] == 2'b11) exp = lb;        // R2 loopback
            else if (code[1:0] == 2'b00) exp = i[0];      // R4/R6 tone phase
            else                       exp = 1'b0;        // R3/R5 idle
            @(negedge clk);
            if (code[2])                 check("R1/R8", exp);
            else if (code[1:0] == 2'b11) check("R2/R8", exp);
            else if (code[1:0] == 2'b01) check("R3", exp);
            else if (code[1:0] == 2'b00) check("R4/R6", exp);
            else                         check("R5", exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        traffic = 1'b1;
        loopd   = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", 1'b0);
        @(negedge clk);
        check("R9", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b1);   // sync reset state selects traffic, which is 1

        // Two passes over all codes, in ascending and descending order.
        for (int c = 0; c < 8; c++) run_code(3'(c), 9, c);
        for (int c = 7; c >= 0; c--) run_code(3'(c), 9, c + 3);

        // R6: tone ended on an odd count above; idle, then tone again from phase 0.
        run_code(3'b001, 4, 1);
        run_code(3'b000, 5, 2);
        run_code(3'b010, 3, 4);
        run_code(3'b000, 6, 5);

        // R7: from idle with traffic held at 1, the switch shows at the third edge.
        run_code(3'b001, 3, 0);
        traffic = 1'b1;
        @(negedge clk);
        {test_n, code_a, code_b} = 3'b100;
        @(negedge clk);
        check("R7", 1'b0);
        @(negedge clk);
        check("R7", 1'b0);
        @(negedge clk);
        check("R7", 1'b1);

        // R3: idle code ignores both data streams being held high.
        {test_n, code_a, code_b} = 3'b001;
        traffic = 1'b1;
        loopd   = 1'b1;
        repeat (3) @(negedge clk);
        check("R3", 1'b0);
        @(negedge clk);
        check("R3", 1'b0);

        // R9: reset in the middle of traffic forces the output low.
        {test_n, code_a, code_b} = 3'b100;
        repeat (3) @(negedge clk);
        check("R1", 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", 1'b0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule